// File: doc/BRIEF.md
# Selectable-Length Input Glitch Qualifier

This block cleans up a vector of asynchronous input pins before they feed capture, external interrupt, conversion-start and fault-shutdown logic. Each pin is brought into the clock domain through a synchroniser chain. A per-pin stability counter then runs behind it. The qualified output of a pin follows the pin only after the synchronised level has differed from the qualified level on a configured number of consecutive clock edges. Any shorter excursion is discarded.

One control input selects the qualification window at run time. Low selects the short window of 6 edges, so pulses of 5 cycles or fewer are rejected. High selects the long window of 12 edges, so pulses of 11 cycles or fewer are rejected. The counter compares against the window chosen in the current cycle. A one-cycle rise or fall pulse can be produced for each qualified transition. Pins used as plain general-purpose I/O do not pass through this block.

Top module: `glitch_qual`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every bit of `qual_o`, `rise_o` and `fall_o` is 0.
- R2: With `long_win_i` = 0, a pin level that differs from `qual_o` and holds for 6 consecutive synchronised samples is taken into `qual_o`. Counting the two synchroniser stages, `qual_o` changes on the 8th rising clock edge after the pin changes.
- R3: With `long_win_i` = 0, a pulse lasting 1 to 5 clock cycles leaves `qual_o` unchanged, and a pulse lasting 6 cycles or more is passed.
- R4: With `long_win_i` = 1, the window is 12 samples, and `qual_o` changes on the 14th rising edge after the pin changes.
- R5: With `long_win_i` = 1, a pulse lasting 11 cycles or less leaves `qual_o` unchanged, and a pulse lasting 12 cycles or more is passed.
- R6: If the synchronised level returns to the qualified level before the window completes, the count restarts from zero. The next qualifying run needs a full window.
- R7: Each pin is qualified independently. Activity on one pin never changes `qual_o` of another pin.
- R8: When `qual_o[i]` goes 0 to 1, `rise_o[i]` is 1 for exactly that first high cycle. When `qual_o[i]` goes 1 to 0, `fall_o[i]` is 1 for exactly that first low cycle. The two pulses are never high together.
- R9: A change of `long_win_i` during a count takes effect on the next edge's comparison. If the run already meets the new, shorter window, the pin qualifies on that edge. If the window is lengthened, the pin qualifies only when the longer count is reached.
- R10: Filtering is symmetric. While `qual_o` is 1, a low pulse shorter than the window leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_win_i | input | 1 | Window select: 0 = 6 edges, 1 = 12 edges |
| pin_i | input | NUM_PINS | Raw asynchronous pin levels |
| qual_o | output | NUM_PINS | Qualified pin levels |
| rise_o | output | NUM_PINS | One-cycle pulse on a qualified rising transition |
| fall_o | output | NUM_PINS | One-cycle pulse on a qualified falling transition |

## Verification
The bench builds the block with three pins, the default windows of 6 and 12, two synchroniser stages and edge pulses enabled. Three pins are enough to show that one pin qualifying while a neighbour glitches leaves the other pins untouched. The default windows put both rejection boundaries, 5 against 6 and 11 against 12, within short runs. Two stages fix the expected edge of every transition at the synchroniser depth plus the window. That makes the mid-count window switch in both directions measurable to the exact cycle.

// File: rtl/gq_pkg.sv
package gq_pkg;

   // Width of a counter that must hold values 0 .. max_count
   function automatic int cnt_width(input int max_count);
      int w;
      w = 1;
      while ((1 << w) <= max_count) w++;
      return w;
   endfunction

   typedef enum logic {
      WIN_SHORT = 1'b0,
      WIN_LONG  = 1'b1
   } win_sel_e;

endpackage

// File: rtl/gq_sync.sv
module gq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin
      assert (STAGES >= 2) else $error("gq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gq_counter.sv
module gq_counter
   import gq_pkg::*;
#(
   parameter int SHORT_WIN = 6,
   parameter int LONG_WIN  = 12
) (
   input  logic     clk,
   input  logic     rst_n,
   input  win_sel_e win_sel_i,
   input  logic     samp_i,
   output logic     qual_o
);

   localparam int CW = cnt_width(LONG_WIN);
   localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_WIN);
   localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_WIN);

   initial begin
      assert (SHORT_WIN >= 1) else $error("gq_counter: SHORT_WIN must be >= 1");
      assert (LONG_WIN > SHORT_WIN) else $error("gq_counter: LONG_WIN must exceed SHORT_WIN");
   end

   logic [CW-1:0] run_q;
   logic [CW-1:0] run_inc;
   logic [CW-1:0] limit;
   logic          differs;
   logic          done;

   assign limit   = (win_sel_i == WIN_LONG) ? LONG_LIM : SHORT_LIM;
   assign differs = samp_i ^ qual_o;
   assign run_inc = run_q + 1'b1;
   assign done    = differs && (run_inc >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         qual_o <= 1'b0;
      end else if (!differs) begin
         run_q  <= '0;
      end else if (done) begin
         run_q  <= '0;
         qual_o <= samp_i;
      end else begin
         run_q  <= run_inc;
      end
   end

   // The qualified level only moves to a value that was being sampled
   assert_follow_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_o != $past(qual_o)) |-> ($past(samp_i) == qual_o));

   // A count never reaches the long window
   assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < LONG_LIM);

   // Agreement between sample and qualified level restarts the run
   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_i == qual_o) |=> (run_q == '0));

   // With a short window the pin never waits past the short count
   assert_short_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (win_sel_i == WIN_SHORT && differs && run_q >= SHORT_LIM - 1'b1) |=> (qual_o == $past(samp_i)));

endmodule

// File: rtl/gq_edge.sv
module gq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);

   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_d;
   assign fall_o = ~lvl_i & lvl_d;

   assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));

   assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

   assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/glitch_qual.sv
module glitch_qual
   import gq_pkg::*;
#(
   parameter int NUM_PINS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SHORT_WIN   = 6,
   parameter int LONG_WIN    = 12,
   parameter bit EDGE_PULSES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                long_win_i,
   input  logic [NUM_PINS-1:0] pin_i,
   output logic [NUM_PINS-1:0] qual_o,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] fall_o
);

   initial begin
      assert (NUM_PINS >= 1) else $error("glitch_qual: NUM_PINS must be >= 1");
   end

   win_sel_e              win_sel;
   logic [NUM_PINS-1:0]   samp;

   assign win_sel = long_win_i ? WIN_LONG : WIN_SHORT;

   generate
      genvar p;
      for (p = 0; p < NUM_PINS; p++) begin : g_pin
         gq_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (pin_i[p]),
            .q_o   (samp[p])
         );

         gq_counter #(
            .SHORT_WIN (SHORT_WIN),
            .LONG_WIN  (LONG_WIN)
         ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .win_sel_i (win_sel),
            .samp_i    (samp[p]),
            .qual_o    (qual_o[p])
         );

         if (EDGE_PULSES) begin : g_edge
            gq_edge u_edge (
               .clk    (clk),
               .rst_n  (rst_n),
               .lvl_i  (qual_o[p]),
               .rise_o (rise_o[p]),
               .fall_o (fall_o[p])
            );
         end else begin : g_no_edge
            assign rise_o[p] = 1'b0;
            assign fall_o[p] = 1'b0;
         end
      end
   endgenerate

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (qual_o == '0));

   assert_rise_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o & ~qual_o) == '0);

endmodule

// File: tb/glitch_qual_tb.sv
module glitch_qual_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 3;
   localparam int NV = 9;

   // entry: {sel[1], pulse length[5], expected rise edge[5]} (0 = no rise)
   localparam logic [10:0] VEC [NV] = '{
      {1'b0, 5'd5,  5'd0},
      {1'b0, 5'd6,  5'd8},
      {1'b0, 5'd1,  5'd0},
      {1'b0, 5'd9,  5'd8},
      {1'b1, 5'd11, 5'd0},
      {1'b1, 5'd12, 5'd14},
      {1'b1, 5'd6,  5'd0},
      {1'b1, 5'd13, 5'd14},
      {1'b0, 5'd4,  5'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          long_win = 1'b0;
   logic [NP-1:0] pin = '0;
   logic [NP-1:0] qual, rise, fall;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   glitch_qual #(.NUM_PINS(NP)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .long_win_i (long_win),
      .pin_i      (pin),
      .qual_o     (qual),
      .rise_o     (rise),
      .fall_o     (fall)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Raise pin 0 at a falling edge, then watch 40 rising edges.
   // The pin drops after edge 'len'. Returns the edge of the rise and pulse counts.
   task automatic pulse_run(input int len, output int first, output int rises, output int falls,
                            output int rise_ok);
      first = 0; rises = 0; falls = 0; rise_ok = 1;
      @(negedge clk);
      pin[0] = 1'b1;
      for (int i = 1; i <= 40; i++) begin
         @(posedge clk); #1;
         if (qual[0] && first == 0) begin
            first = i;
            if (!rise[0]) rise_ok = 0;
         end
         if (rise[0]) rises++;
         if (fall[0]) falls++;
         if (i == len) pin[0] = 1'b0;
      end
   endtask

   initial begin
      int first, rises, falls, rok;
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(qual == '0 && rise == '0 && fall == '0, "R1 outputs during reset", int'(qual), 0);
      @(negedge clk);
      rst_n = 1'b1;
      pin = '1;
      @(posedge clk); #1;
      check(qual == '0, "R1 qual after release", int'(qual), 0);
      check(rise == '0 && fall == '0, "R1 pulses after release", int'({rise, fall}), 0);
      @(negedge clk);
      pin = '0;
      repeat (20) @(posedge clk);

      // Table walk on pin 0: R2 R3 R4 R5 R8
      for (int e = 0; e < NV; e++) begin
         long_win = VEC[e][10];
         pulse_run(int'(VEC[e][9:5]), first, rises, falls, rok);
         check(first == int'(VEC[e][4:0]),
               long_win ? "R4/R5 rise edge (long)" : "R2/R3 rise edge (short)",
               first, int'(VEC[e][4:0]));
         check(rises == (VEC[e][4:0] != 0 ? 1 : 0) && rok == 1, "R8 rise pulse count", rises,
               VEC[e][4:0] != 0 ? 1 : 0);
         check(falls == rises, "R8 fall pulse count", falls, rises);
         check(qual == '0, "R7 all pins low after entry", int'(qual), 0);
         repeat (5) @(posedge clk);
      end

      // R6: high 4 cycles, low 1, then high -> restart, rise at edge 13
      long_win = 1'b0;
      @(negedge clk);
      pin[0] = 1'b1;
      first = 0;
      for (int i = 1; i <= 20; i++) begin
         @(posedge clk); #1;
         if (qual[0] && first == 0) first = i;
         if (i == 4) pin[0] = 1'b0;
         if (i == 5) pin[0] = 1'b1;
      end
      check(first == 13, "R6 restart rise edge", first, 13);

      // R10: low glitch of 5 cycles while qualified high (short window)
      @(negedge clk);
      pin[0] = 1'b0;
      first = 0;
      for (int i = 1; i <= 20; i++) begin
         @(posedge clk); #1;
         if (!qual[0] && first == 0) first = i;
         if (i == 5) pin[0] = 1'b1;
      end
      check(first == 0, "R10 low glitch rejected", first, 0);
      check(qual[0] == 1'b1, "R10 level held high", int'(qual[0]), 1);
      // return pin 0 low
      @(negedge clk);
      pin[0] = 1'b0;
      repeat (20) @(posedge clk);
      #1;
      check(qual == '0, "R10 falls after full window", int'(qual), 0);

      // R7: pin 1 held, pin 2 glitches 3 cycles
      @(negedge clk);
      pin[1] = 1'b1;
      pin[2] = 1'b1;
      repeat (3) @(negedge clk);
      pin[2] = 1'b0;
      repeat (20) @(posedge clk);
      #1;
      check(qual == 3'b010, "R7 independent pins", int'(qual), 2);
      @(negedge clk);
      pin[1] = 1'b0;
      repeat (20) @(posedge clk);

      // R9: long -> short after 9 edges, rise at edge 10
      long_win = 1'b1;
      @(negedge clk);
      pin[0] = 1'b1;
      first = 0;
      for (int i = 1; i <= 20; i++) begin
         @(posedge clk); #1;
         if (qual[0] && first == 0) first = i;
         if (i == 9) long_win = 1'b0;
      end
      check(first == 10, "R9 shortened window", first, 10);
      @(negedge clk);
      pin[0] = 1'b0;
      repeat (20) @(posedge clk);

      // R9: short -> long after 5 edges, rise at edge 14
      long_win = 1'b0;
      @(negedge clk);
      pin[0] = 1'b1;
      first = 0;
      for (int i = 1; i <= 20; i++) begin
         @(posedge clk); #1;
         if (qual[0] && first == 0) first = i;
         if (i == 5) long_win = 1'b1;
      end
      check(first == 14, "R9 lengthened window", first, 14);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule